// File: doc/BRIEF.md
# Event Timer with Selectable Source and Prescaler

An 8-bit up-counter for a small controller core. Each counting event comes from one of two places. The first is the core's instruction-cycle tick. The second is a qualified transition on an external timer pin, and that transition can be either rising or falling. A power-of-two prescaler can sit between the event source and the counter, or it can be bypassed so that every event counts once.

Software uses a control byte to choose the source, the edge and the ratio. It can load the counter at any time, and it clears a sticky wrap flag that the block raises whenever the counter passes its top value. While the sleep input is held, the counter and the prescaler stay frozen.

The external pin passes through a synchroniser. It is then sampled once per instruction tick, and a new pin level is accepted only when two consecutive tick samples both show it. As a result, a pulse narrower than one instruction cycle is never counted.

Top module: `tmr8_timer`

## Requirements
- R1: After reset the counter reads 0, the control byte reads 0 and the wrap flag is 0. Control bits 7 and 6 always read back as 0.
- R2: With control bit 5 = 0 (instruction tick source) and bit 3 = 0 (prescaler bypassed), every tick pulse increments the counter by one. The increment is visible in the cycle after the tick.
- R3: With control bit 3 = 1, a ratio field value n in control bits 2..0 gives one counter increment per 2^(n+1) source events, so the rate spans 1:2 to 1:256. The counter never moves by more than one per cycle.
- R4: With control bit 5 = 1, tick pulses by themselves do not count. Only accepted pin transitions count: rising ones when control bit 4 = 0, falling ones when bit 4 = 1.
- R5: A pin level is accepted only when two consecutive tick samples of the synchronised pin both differ from the current accepted level. A level seen at a single tick sample is dropped and produces no count.
- R6: When the counter steps from 0xFF to 0x00, the wrap flag is set. The flag then stays set until it is cleared, and a wrap in the same cycle as a clear leaves the flag set.
- R7: A clear pulse drops the wrap flag in the next cycle when no wrap happens in that cycle.
- R8: While sleep is high, neither the counter nor the prescaler advances. Counting resumes from the frozen state when sleep falls.
- R9: A counter write loads the written value exactly, even in a cycle that also carries an event. The write also restarts the prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle instruction-cycle tick |
| pin_i | input | 1 | Asynchronous external timer pin |
| sleep_i | input | 1 | Freezes counting while high |
| ctl_wr_i | input | 1 | Write strobe for the control byte |
| ctl_wdata_i | input | 8 | Control byte write data |
| cnt_wr_i | input | 1 | Write strobe for the counter |
| cnt_wdata_i | input | 8 | Counter write data |
| flag_clr_i | input | 1 | Clears the wrap flag |
| ctl_o | output | 8 | Control byte readback |
| cnt_o | output | 8 | Counter value |
| wrap_o | output | 1 | Sticky wrap flag |

## Verification
The hardest case to reach from the ports is the pin qualifier rejecting a pulse. That only happens when a level lands on exactly one tick sample and then reverts before the next one. The stimulus drives the tick itself from a task, leaving the synchroniser three idle cycles to settle before each tick. This lets the bench place a pin level across exactly one or exactly two samples. A second hard case is a prescaler restart that only shows when the counter is written partway through a ratio period, and the bench sets that up by running a partial period before the write.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
   typedef enum logic {SRC_TICK = 1'b0, SRC_PIN = 1'b1} tmr_src_e;
   typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} tmr_edge_e;

   // bit-position helpers for a control byte with an n-bit ratio field at the bottom
   function automatic int pse_pos(input int ratio_w);
      return ratio_w;
   endfunction
   function automatic int edge_pos(input int ratio_w);
      return ratio_w + 1;
   endfunction
   function automatic int src_pos(input int ratio_w);
      return ratio_w + 2;
   endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_pin_qual.sv
module tmr_pin_qual
   import tmr8_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick_i,
   input  logic      pin_s_i,
   input  tmr_edge_e edge_i,
   output logic      evt_o
);
   logic lvl_q;
   logic pend_q;
   logic differs;
   logic take;

   assign differs = (pin_s_i != lvl_q);
   assign take    = tick_i && differs && pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         pend_q <= 1'b0;
         evt_o  <= 1'b0;
      end else begin
         evt_o <= 1'b0;
         if (tick_i) begin
            if (take) begin
               lvl_q  <= pin_s_i;
               pend_q <= 1'b0;
               evt_o  <= (edge_i == EDGE_RISE) ? pin_s_i : !pin_s_i;
            end else begin
               pend_q <= differs;
            end
         end
      end
   end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart_i,
   input  logic               en_i,
   input  logic               evt_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               inc_o
);
   localparam int PS_W = 1 << RATIO_W;

   if (RATIO_W < 1 || RATIO_W > 5) begin : g_bad_ratio
      $error("tmr_prescale: RATIO_W out of range");
   end

   logic [PS_W-1:0] pcnt_q;
   logic [PS_W-1:0] mask;
   logic            hit;

   always_comb begin
      for (int i = 0; i < PS_W; i++) begin
         mask[i] = (i <= int'(ratio_i));
      end
   end

   assign hit   = ((pcnt_q & mask) == mask);
   assign inc_o = en_i ? (evt_i && hit) : evt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (restart_i || !en_i) begin
         pcnt_q <= '0;
      end else if (evt_i) begin
         pcnt_q <= hit ? '0 : pcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
   import tmr8_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int CTL_W       = 8,
   parameter int RATIO_W     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             pin_i,
   input  logic             sleep_i,
   input  logic             ctl_wr_i,
   input  logic [CTL_W-1:0] ctl_wdata_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   input  logic             flag_clr_i,
   output logic [CTL_W-1:0] ctl_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam int PSE_B  = pse_pos(RATIO_W);
   localparam int EDGE_B = edge_pos(RATIO_W);
   localparam int SRC_B  = src_pos(RATIO_W);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   if (SRC_B >= CTL_W) begin : g_bad_ctl
      $error("tmr8_timer: control byte too narrow for the ratio field");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tmr8_timer: CNT_W must be at least 2");
   end

   tmr_src_e           src_q;
   tmr_edge_e          edge_q;
   logic               pse_q;
   logic [RATIO_W-1:0] ratio_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= SRC_TICK;
         edge_q  <= EDGE_RISE;
         pse_q   <= 1'b0;
         ratio_q <= '0;
      end else if (ctl_wr_i) begin
         src_q   <= tmr_src_e'(ctl_wdata_i[SRC_B]);
         edge_q  <= tmr_edge_e'(ctl_wdata_i[EDGE_B]);
         pse_q   <= ctl_wdata_i[PSE_B];
         ratio_q <= ctl_wdata_i[RATIO_W-1:0];
      end
   end

   always_comb begin
      ctl_o                = '0;
      ctl_o[SRC_B]         = src_q;
      ctl_o[EDGE_B]        = edge_q;
      ctl_o[PSE_B]         = pse_q;
      ctl_o[RATIO_W-1:0]   = ratio_q;
   end

   logic pin_s;
   logic pin_evt;
   logic src_evt;
   logic inc;

   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   tmr_pin_qual u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .pin_s_i (pin_s),
      .edge_i  (edge_q),
      .evt_o   (pin_evt)
   );

   assign src_evt = !sleep_i && ((src_q == SRC_PIN) ? pin_evt : tick_i);

   tmr_prescale #(.RATIO_W(RATIO_W)) u_ps (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (cnt_wr_i),
      .en_i      (pse_q),
      .evt_i     (src_evt),
      .ratio_i   (ratio_q),
      .inc_o     (inc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (cnt_wr_i) begin
         cnt_o <= cnt_wdata_i;
      end else if (inc) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wrap_o <= 1'b0;
      end else if (inc && !cnt_wr_i && cnt_o == CNT_TOP) begin
         wrap_o <= 1'b1;
      end else if (flag_clr_i) begin
         wrap_o <= 1'b0;
      end
   end
endmodule

// File: rtl/tmr8_timer_chk.sv
module tmr8_timer_chk #(
   parameter int CNT_W   = 8,
   parameter int CTL_W   = 8,
   parameter int RATIO_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             sleep_i,
   input logic             cnt_wr_i,
   input logic [CNT_W-1:0] cnt_wdata_i,
   input logic             flag_clr_i,
   input logic [CTL_W-1:0] ctl_o,
   input logic [CNT_W-1:0] cnt_o,
   input logic             wrap_o
);
   localparam int PSE_B = RATIO_W;
   localparam int SRC_B = RATIO_W + 2;
   localparam logic [CNT_W-1:0] TOP = '1;

   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_i |=> cnt_o == $past(cnt_wdata_i)); // R9

   AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && !cnt_wr_i) |=> $stable(cnt_o)); // R8

   AST_DIRECT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !sleep_i && !cnt_wr_i && !ctl_o[SRC_B] && !ctl_o[PSE_B])
      |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R2

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr_i |=> (cnt_o == $past(cnt_o) || cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R3

   AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr_i && cnt_o == TOP) |=> (cnt_o == TOP || wrap_o)); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_o && !flag_clr_i) |=> wrap_o); // R6

   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && cnt_o != TOP) |=> !wrap_o); // R7
endmodule

bind tmr8_timer tmr8_timer_chk #(
   .CNT_W   (CNT_W),
   .CTL_W   (CTL_W),
   .RATIO_W (RATIO_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .sleep_i     (sleep_i),
   .cnt_wr_i    (cnt_wr_i),
   .cnt_wdata_i (cnt_wdata_i),
   .flag_clr_i  (flag_clr_i),
   .ctl_o       (ctl_o),
   .cnt_o       (cnt_o),
   .wrap_o      (wrap_o)
);

// File: tb/sim_tmr8_timer.sv
module sim_tmr8_timer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       pin = 1'b0;
   logic       sleep = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       cnt_wr = 1'b0;
   logic [7:0] cnt_wdata = '0;
   logic       flag_clr = 1'b0;
   logic [7:0] ctl_q;
   logic [7:0] cnt_q;
   logic       wrap_q;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr8_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .pin_i(pin), .sleep_i(sleep),
      .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .cnt_wr_i(cnt_wr),
      .cnt_wdata_i(cnt_wdata), .flag_clr_i(flag_clr),
      .ctl_o(ctl_q), .cnt_o(cnt_q), .wrap_o(wrap_q)
   );

   typedef struct packed {
      logic [7:0]  ctl;
      logic [7:0]  pre;
      logic [15:0] ticks;
      logic [7:0]  exp_cnt;
      logic        exp_wrap;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{8'h00, 8'h00, 16'd10,  8'h0A, 1'b0},  // R2 1:1
      '{8'h00, 8'hFE, 16'd3,   8'h01, 1'b1},  // R6 wrap
      '{8'h08, 8'h00, 16'd10,  8'h05, 1'b0},  // R3 1:2
      '{8'h0A, 8'h00, 16'd20,  8'h02, 1'b0},  // R3 1:8
      '{8'h0F, 8'hFF, 16'd256, 8'h00, 1'b1},  // R3 1:256
      '{8'h0C, 8'h10, 16'd64,  8'h12, 1'b0},  // R3 1:32
      '{8'h20, 8'h33, 16'd10,  8'h33, 1'b0}   // R4 ticks ignored
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wr_cnt(input logic [7:0] v);
      cnt_wr = 1'b1; cnt_wdata = v;
      @(negedge clk);
      cnt_wr = 1'b0;
   endtask

   task automatic clr_flag();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 counter", cnt_q, 8'h00);
      check("R1 control", ctl_q, 8'h00);
      check("R1 flag", {7'd0, wrap_q}, 8'h00);
      wr_ctl(8'hFF);
      check("R1 unused control bits", ctl_q, 8'h3F);

      for (int v = 0; v < 7; v++) begin
         wr_ctl(VECS[v].ctl);
         wr_cnt(VECS[v].pre);
         clr_flag();
         run_ticks(int'(VECS[v].ticks));
         check($sformatf("R2/R3/R4 vector %0d count", v), cnt_q, VECS[v].exp_cnt);
         check($sformatf("R6 vector %0d flag", v), {7'd0, wrap_q}, {7'd0, VECS[v].exp_wrap});
      end

      // R4 edge polarity
      wr_ctl(8'h20); wr_cnt(8'h00);
      pin = 1'b1; run_ticks(2);
      check("R4 rising counted", cnt_q, 8'h01);
      pin = 1'b0; run_ticks(2);
      check("R4 falling ignored in rise mode", cnt_q, 8'h01);
      wr_ctl(8'h30);
      pin = 1'b1; run_ticks(2);
      check("R4 rising ignored in fall mode", cnt_q, 8'h01);
      pin = 1'b0; run_ticks(2);
      check("R4 falling counted", cnt_q, 8'h02);

      // R5 narrow pulse rejected, wide pulse accepted
      wr_ctl(8'h20); wr_cnt(8'h00);
      pin = 1'b1; run_ticks(1);
      pin = 1'b0; run_ticks(2);
      check("R5 narrow pulse", cnt_q, 8'h00);
      pin = 1'b1; run_ticks(2);
      check("R5 wide pulse", cnt_q, 8'h01);
      pin = 1'b0; run_ticks(2);

      // R8 sleep freezes counter and prescaler
      wr_ctl(8'h00); wr_cnt(8'h05);
      sleep = 1'b1; run_ticks(5);
      check("R8 counter frozen", cnt_q, 8'h05);
      sleep = 1'b0; run_ticks(2);
      check("R8 resumes", cnt_q, 8'h07);
      wr_ctl(8'h08); wr_cnt(8'h00);
      run_ticks(1);
      sleep = 1'b1; run_ticks(3);
      sleep = 1'b0; run_ticks(1);
      check("R8 prescaler frozen", cnt_q, 8'h01);

      // R9 write beats same-cycle event, restarts prescaler
      wr_ctl(8'h00); wr_cnt(8'h00);
      tick = 1'b1; cnt_wr = 1'b1; cnt_wdata = 8'h80;
      @(negedge clk);
      tick = 1'b0; cnt_wr = 1'b0;
      check("R9 write with tick", cnt_q, 8'h80);
      wr_ctl(8'h09); wr_cnt(8'h00);
      run_ticks(3);
      wr_cnt(8'h40);
      run_ticks(3);
      check("R9 prescaler restarted", cnt_q, 8'h40);
      run_ticks(1);
      check("R9 fourth event", cnt_q, 8'h41);

      // R6 sticky flag, R7 clear, set wins over clear
      wr_ctl(8'h00); wr_cnt(8'hFF); clr_flag();
      run_ticks(1);
      check("R6 wrap value", cnt_q, 8'h00);
      check("R6 flag set", {7'd0, wrap_q}, 8'h01);
      run_ticks(3);
      check("R6 flag sticky", {7'd0, wrap_q}, 8'h01);
      clr_flag();
      check("R7 flag cleared", {7'd0, wrap_q}, 8'h00);
      wr_cnt(8'hFF);
      tick = 1'b1; flag_clr = 1'b1;
      @(negedge clk);
      tick = 1'b0; flag_clr = 1'b0;
      check("R6 set wins over clear", {7'd0, wrap_q}, 8'h01);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule